// File: doc/BRIEF.md
# Sample-Rate-Dependent Reference Clock Scaler

This block derives a reference clock output from the synthesizer clock. The output toggles only while the processor enable or the codec enable is high. The division ratio is chosen automatically from a sample-rate class code: the scaler divides by 1, 2 or 4. A small lookup table, set by parameter, holds that mapping.

Two bits of a configuration word adjust the result. One adds a further halving after the scaler. The other bypasses the scaler, so only the optional halving stays in the path. The configuration word can be written only while the processor enable is high. Whatever was last written stays in force after the processor enable is cleared.

When a ratio change is requested, the period in progress is finished first and the new ratio starts at the next period boundary. No output pulse is cut short by a ratio change. Outputs with a ratio of 2 or more have a 50 % duty cycle and start each period with the high phase. A ratio of 1 passes the synthesizer clock through.

Top module: `clk_ref_scaler`

## Requirements
- R1: When `proc_en` and `codec_en` are both low, `clk_out` is held low from the second `synth_clk` rising edge onward and shows no rising edge.
- R2: With configuration bits 8 and 17 both clear, the output period is the synthesizer period times the scaler ratio. The ratio comes from `rate_class`: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4, and 2'b11 is treated as 4.
- R3: For a total ratio N of 2 or more, `clk_out` is high for the first N/2 synthesizer cycles of each period and low for the rest. For N = 1, `clk_out` follows `synth_clk`: 2 ns high and 2 ns low at the bench clock.
- R4: Configuration bit 17 set doubles the total ratio after the scaler.
- R5: Configuration bit 8 set bypasses the scaler, so the ratio is 1 whatever `rate_class` is. Bit 17 still doubles it.
- R6: A write on `cfg_wdata` with `cfg_we` high is taken only on a rising edge where `proc_en` is high. Data bits other than 8 and 17 have no effect on the output.
- R7: Clearing `proc_en` keeps the stored configuration. With only `codec_en` high, the output keeps running with that configuration.
- R8: A change of `rate_class` or of the configuration takes effect only at the next period boundary. The rising edge that follows a change comes one full old period after the previous rising edge.
- R9: Reset clears both configuration bits: the scaler is active and the extra halving is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| synth_clk | input | 1 | Synthesizer clock; the source of the output and the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_en | input | 1 | Processor enable; also allows configuration writes |
| codec_en | input | 1 | Audio codec enable |
| rate_class | input | CLASS_W (2) | Sample-rate class code used to pick the scaler ratio |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W (24) | Configuration write data; bit 8 bypasses the scaler, bit 17 adds a further halving |
| clk_out | output | 1 | Divided reference clock |

## Verification
The scaler is driven with every class code, from 00 to the aliased 11, and each one must give its own output period. This shows that the table lookup and the alias are separate cases. The extra-halving and bypass bits are applied alone and together, so that an extra factor of two can be told apart from a missing one. Writes are made with only the codec enabled and with data whose other bits are set. These show whether the write gate and the field decode leak. A class change made in the middle of a long period, followed by the measured spacing of the next two rising edges, shows whether the new ratio waits for the period boundary.

// File: rtl/clkscl_pkg.sv
package clkscl_pkg;

   typedef struct packed {
      logic extra_div;
      logic bypass;
   } clkscl_cfg_t;

   function automatic int clog2_min1(input int value);
      int bits;
      bits = 1;
      while ((1 << bits) < value) bits++;
      return bits;
   endfunction

endpackage

// File: rtl/clkscl_cfg_reg.sv
module clkscl_cfg_reg
   import clkscl_pkg::*;
#(
   parameter int CFG_W      = 24,
   parameter int BYPASS_BIT = 8,
   parameter int EXTRA_BIT  = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_allow,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output clkscl_cfg_t      cfg
);

   clkscl_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we && wr_allow) begin
         cfg_q.bypass    <= wdata[BYPASS_BIT];
         cfg_q.extra_div <= wdata[EXTRA_BIT];
      end
   end

   assign cfg = cfg_q;

endmodule

// File: rtl/clkscl_ratio_sel.sv
module clkscl_ratio_sel
   import clkscl_pkg::*;
#(
   parameter int CLASS_W     = 2,
   parameter int ENTRY_W     = 2,
   parameter int K_W         = 2,
   parameter int NUM_CLASSES = 4,
   parameter logic [NUM_CLASSES*ENTRY_W-1:0] RATE_MAP = '0
) (
   input  logic [CLASS_W-1:0] rate_class,
   input  clkscl_cfg_t        cfg,
   output logic [K_W-1:0]     shift_req
);

   logic [ENTRY_W-1:0] tab [NUM_CLASSES];

   for (genvar gi = 0; gi < NUM_CLASSES; gi++) begin : g_tab
      assign tab[gi] = RATE_MAP[gi*ENTRY_W +: ENTRY_W];
   end

   logic [K_W-1:0] scale_shift;

   always_comb begin
      if (cfg.bypass) scale_shift = '0;
      else            scale_shift = K_W'(tab[rate_class]);
      shift_req = scale_shift + K_W'(cfg.extra_div);
   end

endmodule

// File: rtl/clkscl_div_core.sv
module clkscl_div_core #(
   parameter int CNT_W = 3,
   parameter int K_W   = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic [K_W-1:0] shift_req,
   output logic [K_W-1:0] applied_shift,
   output logic           period_start,
   output logic           clk_out
);

   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
   logic [K_W-1:0]   k_q, k_d;
   logic             on_q;
   logic             lvl_q, lvl_d;
   logic             pass_p_q, pass_p_d;
   logic             pass_n_q;

   function automatic logic [CNT_W-1:0] last_of(input logic [K_W-1:0] k);
      logic [CNT_W:0] span;
      span = {{CNT_W{1'b0}}, 1'b1} << k;
      return CNT_W'(span - 1'b1);
   endfunction

   function automatic logic [CNT_W-1:0] half_of(input logic [K_W-1:0] k);
      logic [CNT_W:0] span;
      span = {{CNT_W{1'b0}}, 1'b1} << k;
      return CNT_W'(span >> 1);
   endfunction

   assign cnt_inc      = cnt_q + 1'b1;
   assign period_start = run && (!on_q || (cnt_q == last_of(k_q)));

   always_comb begin
      cnt_d    = cnt_inc;
      k_d      = k_q;
      lvl_d    = (cnt_inc < half_of(k_q));
      pass_p_d = pass_p_q;
      if (!run) begin
         cnt_d    = '0;
         k_d      = shift_req;
         lvl_d    = 1'b0;
         pass_p_d = 1'b0;
      end else if (period_start) begin
         cnt_d    = '0;
         k_d      = shift_req;
         lvl_d    = 1'b1;
         pass_p_d = (shift_req == '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         k_q      <= '0;
         on_q     <= 1'b0;
         lvl_q    <= 1'b0;
         pass_p_q <= 1'b0;
      end else begin
         cnt_q    <= cnt_d;
         k_q      <= k_d;
         on_q     <= run;
         lvl_q    <= lvl_d;
         pass_p_q <= pass_p_d;
      end
   end

   // pass-through is opened only while the source clock is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) pass_n_q <= 1'b0;
      else        pass_n_q <= pass_p_q;
   end

   assign applied_shift = k_q;
   assign clk_out       = (pass_p_q && pass_n_q) ? clk : lvl_q;

endmodule

// File: rtl/clk_ref_scaler.sv
module clk_ref_scaler
   import clkscl_pkg::*;
#(
   parameter int CFG_W           = 24,
   parameter int BYPASS_BIT      = 8,
   parameter int EXTRA_BIT       = 17,
   parameter int CLASS_W         = 2,
   parameter int MAX_SCALE_SHIFT = 2,
   parameter int ENTRY_W         = 2,
   parameter logic [(1<<CLASS_W)*ENTRY_W-1:0] RATE_MAP = 8'b10_10_01_00
) (
   input  logic               synth_clk,
   input  logic               rst_n,
   input  logic               proc_en,
   input  logic               codec_en,
   input  logic [CLASS_W-1:0] rate_class,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_wdata,
   output logic               clk_out
);

   localparam int NUM_CLASSES = 1 << CLASS_W;
   localparam int TOT_SHIFT   = MAX_SCALE_SHIFT + 1;
   localparam int CNT_W       = TOT_SHIFT;
   localparam int K_W         = clog2_min1(TOT_SHIFT + 1);

   if (BYPASS_BIT >= CFG_W || EXTRA_BIT >= CFG_W) begin : g_bad_bitpos
      $error("configuration bit position outside the word");
   end
   if (BYPASS_BIT == EXTRA_BIT) begin : g_bad_overlap
      $error("bypass and extra-divide bits must differ");
   end
   if ((1 << ENTRY_W) <= MAX_SCALE_SHIFT) begin : g_bad_entry
      $error("table entry too narrow for the largest scaler shift");
   end
   for (genvar gc = 0; gc < NUM_CLASSES; gc++) begin : g_map_chk
      if (RATE_MAP[gc*ENTRY_W +: ENTRY_W] > MAX_SCALE_SHIFT) begin : g_bad_map
         $error("rate map entry exceeds the largest scaler shift");
      end
   end

   clkscl_cfg_t    cfg;
   logic [K_W-1:0] shift_req;
   logic [K_W-1:0] applied_shift;
   logic           period_start;
   logic           run;

   assign run = proc_en | codec_en;

   clkscl_cfg_reg #(
      .CFG_W      (CFG_W),
      .BYPASS_BIT (BYPASS_BIT),
      .EXTRA_BIT  (EXTRA_BIT)
   ) u_cfg (
      .clk      (synth_clk),
      .rst_n    (rst_n),
      .wr_allow (proc_en),
      .we       (cfg_we),
      .wdata    (cfg_wdata),
      .cfg      (cfg)
   );

   clkscl_ratio_sel #(
      .CLASS_W     (CLASS_W),
      .ENTRY_W     (ENTRY_W),
      .K_W         (K_W),
      .NUM_CLASSES (NUM_CLASSES),
      .RATE_MAP    (RATE_MAP)
   ) u_sel (
      .rate_class (rate_class),
      .cfg        (cfg),
      .shift_req  (shift_req)
   );

   clkscl_div_core #(
      .CNT_W (CNT_W),
      .K_W   (K_W)
   ) u_core (
      .clk           (synth_clk),
      .rst_n         (rst_n),
      .run           (run),
      .shift_req     (shift_req),
      .applied_shift (applied_shift),
      .period_start  (period_start),
      .clk_out       (clk_out)
   );

endmodule

// File: rtl/clkscl_chk.sv
module clkscl_chk #(
   parameter int CFG_W      = 24,
   parameter int BYPASS_BIT = 8,
   parameter int EXTRA_BIT  = 17,
   parameter int K_W        = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             proc_en,
   input logic             codec_en,
   input logic             cfg_we,
   input logic [CFG_W-1:0] cfg_wdata,
   input logic             cfg_bypass,
   input logic             cfg_extra,
   input logic [K_W-1:0]   applied_shift,
   input logic             period_start,
   input logic             clk_out
);

   AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_en && !codec_en && $past(!proc_en && !codec_en)) |-> !clk_out); // R1

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !proc_en |=> ($stable(cfg_bypass) && $stable(cfg_extra))); // R7

   AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_en && cfg_we) |=> (cfg_bypass == $past(cfg_wdata[BYPASS_BIT]) &&
                               cfg_extra  == $past(cfg_wdata[EXTRA_BIT]))); // R6

   AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      ((proc_en || codec_en) && $past(proc_en || codec_en) &&
       applied_shift != $past(applied_shift)) |-> $past(period_start)); // R8

endmodule

bind clk_ref_scaler clkscl_chk #(
   .CFG_W      (CFG_W),
   .BYPASS_BIT (BYPASS_BIT),
   .EXTRA_BIT  (EXTRA_BIT),
   .K_W        (K_W)
) i_clkscl_chk (
   .clk           (synth_clk),
   .rst_n         (rst_n),
   .proc_en       (proc_en),
   .codec_en      (codec_en),
   .cfg_we        (cfg_we),
   .cfg_wdata     (cfg_wdata),
   .cfg_bypass    (cfg.bypass),
   .cfg_extra     (cfg.extra_div),
   .applied_shift (applied_shift),
   .period_start  (period_start),
   .clk_out       (clk_out)
);

// File: tb/test_clk_ref_scaler.sv
`timescale 1ns/1ps
module test_clk_ref_scaler;

   logic        synth_clk = 1'b0;
   logic        rst_n     = 1'b0;
   logic        proc_en   = 1'b0;
   logic        codec_en  = 1'b0;
   logic [1:0]  rate_class = 2'b00;
   logic        cfg_we    = 1'b0;
   logic [23:0] cfg_wdata = '0;
   logic        clk_out;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;

   longint last_rise = 0, prev_rise = 0, last_high = 0;
   int     rise_cnt  = 0;
   longint rt [4];
   int     cap_idx   = 0;
   bit     cap_on    = 1'b0;

   localparam int B_BYP = 8;
   localparam int B_EXT = 17;

   always #2 synth_clk = ~synth_clk;

   clk_ref_scaler i_clk_ref_scaler (
      .synth_clk  (synth_clk),
      .rst_n      (rst_n),
      .proc_en    (proc_en),
      .codec_en   (codec_en),
      .rate_class (rate_class),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .clk_out    (clk_out)
   );

   always @(posedge clk_out) begin
      prev_rise = last_rise;
      last_rise = $time;
      rise_cnt++;
      if (cap_on && cap_idx < 4) begin
         rt[cap_idx] = $time;
         cap_idx++;
      end
   end

   always @(negedge clk_out) last_high = $time - last_rise;

   task automatic chk(input string tag, input longint got, input longint exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic cfg_write(input logic [23:0] data);
      @(negedge synth_clk);
      cfg_we    = 1'b1;
      cfg_wdata = data;
      @(negedge synth_clk);
      cfg_we    = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic chk_period(input string tag, input longint exp_ns);
      repeat (48) @(negedge synth_clk);
      chk(tag, last_rise - prev_rise, exp_ns);
   endtask

   task automatic t_reset_state;
      chk("R1 output low in reset", longint'(clk_out), 0);
      chk("R1 no edges in reset", rise_cnt, 0);
      @(negedge synth_clk);
      rst_n = 1'b1;
      proc_en = 1'b1;
      rate_class = 2'b01;
      chk_period("R9 cleared config, class 01 period", 8);
   endtask

   task automatic t_classes;
      rate_class = 2'b00; chk_period("R2 class 00 period", 4);
      chk("R3 ratio 1 high time", last_high, 2);
      rate_class = 2'b01; chk_period("R2 class 01 period", 8);
      chk("R3 ratio 2 high time", last_high, 4);
      rate_class = 2'b10; chk_period("R2 class 10 period", 16);
      chk("R3 ratio 4 high time", last_high, 8);
      rate_class = 2'b11; chk_period("R2 class 11 period", 16);
   endtask

   task automatic t_extra;
      cfg_write(24'(1) << B_EXT);
      rate_class = 2'b01; chk_period("R4 extra halving, class 01", 16);
      rate_class = 2'b00; chk_period("R4 extra halving, class 00", 8);
      rate_class = 2'b10; chk_period("R4 extra halving, class 10", 32);
      chk("R3 ratio 8 high time", last_high, 16);
   endtask

   task automatic t_bypass;
      rate_class = 2'b10;
      cfg_write((24'(1) << B_EXT) | (24'(1) << B_BYP));
      chk_period("R5 bypass with extra halving", 8);
      cfg_write(24'(1) << B_BYP);
      chk_period("R5 bypass alone", 4);
   endtask

   task automatic t_write_gate;
      cfg_write(24'hFE_FEFF & ~((24'(1) << B_EXT) | (24'(1) << B_BYP)));
      rate_class = 2'b01;
      chk_period("R6 other data bits ignored", 8);
      cfg_write(24'(1) << B_EXT);
      chk_period("R7 setup before processor off", 16);
      @(negedge synth_clk);
      codec_en = 1'b1;
      proc_en  = 1'b0;
      chk_period("R7 kept with codec only", 16);
      cfg_write(24'h000000);
      chk_period("R6 write ignored without processor enable", 16);
   endtask

   task automatic t_off;
      int edges_before;
      @(negedge synth_clk);
      codec_en = 1'b0;
      proc_en  = 1'b0;
      repeat (4) @(negedge synth_clk);
      edges_before = rise_cnt;
      for (int i = 0; i < 40; i++) begin
         @(negedge synth_clk);
         chk("R1 low while disabled (low phase)", longint'(clk_out), 0);
         @(posedge synth_clk);
         #1;
         chk("R1 low while disabled (high phase)", longint'(clk_out), 0);
      end
      chk("R1 no edges while disabled", rise_cnt - edges_before, 0);
      @(negedge synth_clk);
      proc_en = 1'b1;
      chk_period("R7 config survives full disable", 16);
   endtask

   task automatic t_boundary;
      cfg_write(24'h000000);
      rate_class = 2'b10;
      repeat (40) @(negedge synth_clk);
      cap_idx = 0;
      cap_on  = 1'b1;
      wait (cap_idx == 1);
      @(negedge synth_clk);
      rate_class = 2'b00;
      repeat (30) @(negedge synth_clk);
      cap_on = 1'b0;
      chk("R8 old period completes", rt[1] - rt[0], 16);
      chk("R8 new period after boundary", rt[2] - rt[1], 4);
      cap_idx = 0;
      cap_on  = 1'b1;
      wait (cap_idx == 1);
      @(negedge synth_clk);
      rate_class = 2'b10;
      repeat (40) @(negedge synth_clk);
      cap_on = 1'b0;
      chk("R8 ratio 1 to 4, first gap", rt[1] - rt[0], 4);
      chk("R8 ratio 1 to 4, second gap", rt[2] - rt[1], 16);
   endtask

   task automatic t_reset_clears;
      cfg_write((24'(1) << B_EXT) | (24'(1) << B_BYP));
      @(negedge synth_clk);
      rst_n = 1'b0;
      @(negedge synth_clk);
      rst_n = 1'b1;
      rate_class = 2'b01;
      chk_period("R9 reset clears config", 8);
   endtask

   initial begin
      repeat (3) @(negedge synth_clk);
      t_reset_state();
      t_classes();
      t_extra();
      t_bypass();
      t_write_gate();
      t_off();
      t_boundary();
      t_reset_clears();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(100000 * 4);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule